// File: doc/BRIEF.md
# Multi-rate TDM slot timing unit

This block sets the timing of a serial time-division multiplex port. On every local-clock event it keeps a bit position and a slot position within the frame. A frame-sync pulse restarts both at zero. From a three-bit rate and group field, it works out how many slots a frame holds. On a 4.096 or 8.192 Mb/s multiplex, it also works out which interleaved group of slots belongs to this device. That group carries the same amount of data as one 2.048 Mb/s stream.

A double-clock control handles a local clock that runs at twice the bit rate. In that mode each bit spans two clock events, and input data is taken on the second one. The block samples the serial input in the device's own slots and reports each sampled bit with a one-cycle strobe. It also produces the data-out drive enable, which a high-impedance control can override. A fixed-rate control pins the multiplex at 2.048 Mb/s, for the control modes that cannot program the rate. Each rising edge of `clk` stands for one falling edge of the line clock. The rate field resets to its 2.048 Mb/s value in the register that feeds it.

Top module: `tdm_slot_timer`

## Requirements
- R1: While `rst_n` is low, `bit_pos` and `slot_pos` read 0 and `smp_vld` reads 0.
- R2: A clock edge with `fsync` high sets `bit_pos` and `slot_pos` to 0 on the next cycle, whatever their previous values, and samples no data.
- R3: With `cfg_dbl` = 0, each clock edge without `fsync` advances `bit_pos` by one, wrapping 7 to 0. The wrap advances `slot_pos` by one.
- R4: With `cfg_dbl` = 1, the position advances only on every second edge after the frame sync. The first edge after the sync holds the position, and the second edge advances it.
- R5: `cfg_rate` = {hi, mid, lo}. With hi = 1 a frame has 128 slots; with hi = 0 and mid = 1 it has 64; with both 0 it has 32. `slot_pos` wraps from the last slot to 0.
- R6: For 64-slot frames there are two interleaved groups. `slot_valid` is 1 exactly when `slot_pos` mod 2 equals bit lo of `cfg_rate`.
- R7: For 128-slot frames there are four interleaved groups. `slot_valid` is 1 exactly when `slot_pos` mod 4 equals {mid, lo} of `cfg_rate`. For 32-slot frames every slot is valid.
- R8: With `cfg_fixed` = 1 the frame has 32 slots, all of them valid, whatever `cfg_rate` holds.
- R9: `smp_vld` pulses in the cycle after each advancing edge whose slot was valid. `smp_bit` then holds the `din` value present at that edge. `smp_vld` stays 0 after any other edge.
- R10: `dout_en` is 1 exactly when `slot_valid` is 1, `slot_oe` is 1 and `cfg_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; each rising edge is one line-clock event |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, high for one cycle before slot 0 bit 0 |
| cfg_rate | input | 3 | Rate and slot-group select {hi, mid, lo} |
| cfg_fixed | input | 1 | Forces 2.048 Mb/s framing |
| cfg_dbl | input | 1 | Local clock at twice the bit rate |
| cfg_hiz | input | 1 | Forces the data-out drive off |
| slot_oe | input | 1 | Output enable for the device's slots |
| din | input | 1 | Serial data in |
| bit_pos | output | 3 | Bit position within the slot |
| slot_pos | output | 7 | Slot position within the frame |
| slot_valid | output | 1 | Current slot belongs to this device |
| smp_vld | output | 1 | A sampled bit is presented |
| smp_bit | output | 1 | Sampled input bit |
| dout_en | output | 1 | Data-out drive enable |

## Verification
The assertions assume that the configuration inputs change only in a cycle where `fsync` is high. That way, no slot position left over from a longer frame is checked against a shorter one, and the double-clock phase always starts from a frame sync. The stimulus changes rate, group, clock mode and fixed-rate settings only together with a sync pulse. Between syncs it holds them steady. It runs each setting through at least one full frame and wrap, then resynchronises part-way through a frame.

// File: rtl/tdm_slot_pkg.sv
// Shared constants and rate-mode decoding for the TDM slot timing unit.
// Assumes a three-bit rate field {hi, mid, lo} as described in the brief.
package tdm_slot_pkg;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,   // 32 slots, one group
        RATE_X2 = 2'd1,   // 64 slots, two groups
        RATE_X4 = 2'd2    // 128 slots, four groups
    } rate_mode_e;

    // Maps the rate field and fixed-rate control to a framing mode.
    function automatic rate_mode_e decode_mode(input logic [2:0] rate, input logic fixed);
        if (fixed)
            return RATE_X1;
        else if (rate[2])
            return RATE_X4;
        else if (rate[1])
            return RATE_X2;
        else
            return RATE_X1;
    endfunction

endpackage

// File: rtl/tdm_rate_decode.sv
// Rate decoder: gives the last slot index, group mask and group number for
// the current framing mode. Pure combinational; assumes GRP_W >= 2.
module tdm_rate_decode #(
    parameter int unsigned BASE_W = 5,
    parameter int unsigned GRP_W  = 2,
    localparam int unsigned SLOT_W = BASE_W + GRP_W
) (
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_fixed,
    output logic [SLOT_W-1:0] last_slot,
    output logic [GRP_W-1:0]  grp_mask,
    output logic [GRP_W-1:0]  grp_sel
);
    import tdm_slot_pkg::*;

    rate_mode_e mode;

    // Derives the frame length and the owned slot group from the mode.
    always_comb begin
        mode = decode_mode(cfg_rate, cfg_fixed);
        unique case (mode)
            RATE_X4: begin
                last_slot = SLOT_W'((1 << (BASE_W + 2)) - 1);
                grp_mask  = GRP_W'(3);
                grp_sel   = GRP_W'(cfg_rate[1:0]);
            end
            RATE_X2: begin
                last_slot = SLOT_W'((1 << (BASE_W + 1)) - 1);
                grp_mask  = GRP_W'(1);
                grp_sel   = GRP_W'(cfg_rate[0]);
            end
            default: begin
                last_slot = SLOT_W'((1 << BASE_W) - 1);
                grp_mask  = '0;
                grp_sel   = '0;
            end
        endcase
    end
endmodule

// File: rtl/tdm_bit_strobe.sv
// Shift strobe generator: one strobe per line bit. In double-clock mode it
// fires on the second of each pair of clock events counted from frame sync.
module tdm_bit_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic cfg_dbl,
    output logic shift_en
);
    logic phase_q;

    // Tracks which half of a doubled bit the current clock event is.
    always_ff @(posedge clk) begin
        if (!rst_n || fsync)
            phase_q <= 1'b0;
        else if (cfg_dbl)
            phase_q <= ~phase_q;
        else
            phase_q <= 1'b0;
    end

    // Strobe on every event, or on the second half of a doubled bit.
    assign shift_en = !fsync && (!cfg_dbl || phase_q);
endmodule

// File: rtl/tdm_pos_counter.sv
// Bit and slot position counters. Cleared by frame sync, advanced by the
// shift strobe, slot wrapping at the supplied last-slot index.
module tdm_pos_counter #(
    parameter int unsigned BIT_W  = 3,
    parameter int unsigned SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              shift_en,
    input  logic [SLOT_W-1:0] last_slot,
    output logic [BIT_W-1:0]  bit_q,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [BIT_W-1:0] BIT_LAST = '1;

    // Advances bit position, carrying into the slot position on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || fsync) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (shift_en) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == BIT_LAST)
                slot_q <= (slot_q >= last_slot) ? '0 : slot_q + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_slot_timer.sv
// Top of the TDM slot timing unit: counts bits and slots, flags the slots
// owned by this device, samples din in them and drives the data-out enable.
// Assumes configuration changes only alongside a frame sync pulse.
module tdm_slot_timer #(
    parameter int unsigned BIT_W  = 3,
    parameter int unsigned BASE_W = 5,
    parameter int unsigned GRP_W  = 2,
    localparam int unsigned SLOT_W = BASE_W + GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_fixed,
    input  logic              cfg_dbl,
    input  logic              cfg_hiz,
    input  logic              slot_oe,
    input  logic              din,
    output logic [BIT_W-1:0]  bit_pos,
    output logic [SLOT_W-1:0] slot_pos,
    output logic              slot_valid,
    output logic              smp_vld,
    output logic              smp_bit,
    output logic              dout_en
);
    logic [SLOT_W-1:0] last_slot;
    logic [GRP_W-1:0]  grp_mask;
    logic [GRP_W-1:0]  grp_sel;
    logic              shift_en;

    tdm_rate_decode #(.BASE_W(BASE_W), .GRP_W(GRP_W)) u_dec (
        .cfg_rate  (cfg_rate),
        .cfg_fixed (cfg_fixed),
        .last_slot (last_slot),
        .grp_mask  (grp_mask),
        .grp_sel   (grp_sel)
    );

    tdm_bit_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .cfg_dbl  (cfg_dbl),
        .shift_en (shift_en)
    );

    tdm_pos_counter #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .shift_en  (shift_en),
        .last_slot (last_slot),
        .bit_q     (bit_pos),
        .slot_q    (slot_pos)
    );

    // Ownership: low slot bits, masked to the group count, match the group.
    assign slot_valid = ((slot_pos[GRP_W-1:0] & grp_mask) == (grp_sel & grp_mask));

    // Drive enable gated by the slot enable and the high-impedance control.
    assign dout_en = slot_valid && slot_oe && !cfg_hiz;

    // Captures din on each advancing edge of an owned slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_vld <= 1'b0;
            smp_bit <= 1'b0;
        end else begin
            smp_vld <= shift_en && slot_valid;
            if (shift_en && slot_valid)
                smp_bit <= din;
        end
    end
endmodule

// File: rtl/tdm_slot_timer_chk.sv
// Checker for the TDM slot timing unit, bound to every instance of the top.
// Assumes configuration inputs change only in a cycle with fsync high.
module tdm_slot_timer_chk #(
    parameter int unsigned BIT_W  = 3,
    parameter int unsigned SLOT_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic [2:0]        cfg_rate,
    input logic              cfg_fixed,
    input logic              cfg_dbl,
    input logic              cfg_hiz,
    input logic [BIT_W-1:0]  bit_pos,
    input logic [SLOT_W-1:0] slot_pos,
    input logic              slot_valid,
    input logic              smp_vld,
    input logic              dout_en
);
    int unsigned frame_slots;

    // Expected frame length from the configuration pins.
    always_comb begin
        if (cfg_fixed)        frame_slots = 32;
        else if (cfg_rate[2]) frame_slots = 128;
        else if (cfg_rate[1]) frame_slots = 64;
        else                  frame_slots = 32;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (bit_pos == '0 && slot_pos == '0 && !smp_vld)); // R1

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (bit_pos == '0 && slot_pos == '0)); // R2

    AST_SYNC_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !smp_vld); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && !cfg_dbl) |=> (bit_pos == $past(bit_pos) + 1'b1)); // R3

    AST_DOUBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dbl && !fsync && !$stable(bit_pos)) |=> (fsync || !cfg_dbl || $stable(bit_pos))); // R4

    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |-> (32'(slot_pos) < frame_slots)); // R5

    AST_SAMPLE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> $past(slot_valid)); // R9

    AST_HIZ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hiz |-> !dout_en); // R10

    AST_FIXED_ALL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fixed |-> slot_valid); // R8
endmodule

bind tdm_slot_timer tdm_slot_timer_chk #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .cfg_rate   (cfg_rate),
    .cfg_fixed  (cfg_fixed),
    .cfg_dbl    (cfg_dbl),
    .cfg_hiz    (cfg_hiz),
    .bit_pos    (bit_pos),
    .slot_pos   (slot_pos),
    .slot_valid (slot_valid),
    .smp_vld    (smp_vld),
    .dout_en    (dout_en)
);

// File: tb/tdm_slot_timer_tb.sv
// Sweeps every rate/group code in both clock modes, plus fixed-rate and
// output-control cases, comparing each cycle against arithmetic expectations.
module tdm_slot_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic [2:0] cfg_rate = 3'd0;
    logic       cfg_fixed = 1'b0;
    logic       cfg_dbl = 1'b0;
    logic       cfg_hiz = 1'b0;
    logic       slot_oe = 1'b0;
    logic       din = 1'b0;
    logic [2:0] bit_pos;
    logic [6:0] slot_pos;
    logic       slot_valid;
    logic       smp_vld;
    logic       smp_bit;
    logic       dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tdm_slot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .cfg_rate(cfg_rate),
        .cfg_fixed(cfg_fixed), .cfg_dbl(cfg_dbl), .cfg_hiz(cfg_hiz),
        .slot_oe(slot_oe), .din(din), .bit_pos(bit_pos), .slot_pos(slot_pos),
        .slot_valid(slot_valid), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .dout_en(dout_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Runs one frame setting from a sync pulse for ncyc clock events.
    task automatic run(input logic [2:0] rate, input bit dbl, input bit fixed,
                       input bit hiz, input bit oe, input int ncyc);
        int nslots, ngrp, sel;
        bit prev_take, prev_din;
        nslots = fixed ? 32 : rate[2] ? 128 : rate[1] ? 64 : 32;
        ngrp   = nslots / 32;
        sel    = fixed ? 0 : rate[2] ? int'(rate[1:0]) : rate[1] ? int'(rate[0]) : 0;
        cfg_rate = rate; cfg_dbl = dbl; cfg_fixed = fixed;
        cfg_hiz = hiz; slot_oe = oe; fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        prev_take = 1'b0; prev_din = 1'b0;
        for (int e = 0; e < ncyc; e++) begin
            int b, ebit, eslot;
            bit own, strobe;
            b     = dbl ? e / 2 : e;
            ebit  = b % 8;
            eslot = (b / 8) % nslots;
            own   = (eslot % ngrp) == sel;
            // R2 R3 R4 R5: position after e edges since the sync
            check(dbl ? "R4" : (e == 0 ? "R2" : "R3"), "bit_pos", int'(bit_pos), ebit);
            check("R5", "slot_pos", int'(slot_pos), eslot);
            check(fixed ? "R8" : (ngrp == 4 ? "R7" : "R6"), "slot_valid", int'(slot_valid), int'(own));
            check("R10", "dout_en", int'(dout_en), int'(own && oe && !hiz));
            check("R9", "smp_vld", int'(smp_vld), int'(prev_take));
            if (prev_take)
                check("R9", "smp_bit", int'(smp_bit), int'(prev_din));
            din = ((e * 7 + 3) % 5) < 2;
            strobe = !dbl || (e % 2 == 1);
            prev_take = strobe && own;
            prev_din = din;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state held at zero during reset
        check("R1", "bit_pos", int'(bit_pos), 0);
        check("R1", "slot_pos", int'(slot_pos), 0);
        check("R1", "smp_vld", int'(smp_vld), 0);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) begin
            for (int d = 0; d < 2; d++) begin
                int n;
                n = (r >= 4 ? 128 : r >= 2 ? 64 : 32) * 8 * (d + 1) + 20;
                run(3'(r), bit'(d), 1'b0, 1'b0, 1'b1, n);
            end
        end
        // R8: fixed rate ignores the rate field
        run(3'd7, 1'b0, 1'b1, 1'b0, 1'b1, 280);
        run(3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 540);
        // R10: output controls
        run(3'd6, 1'b0, 1'b0, 1'b1, 1'b1, 80);
        run(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 80);
        // R2: resync part-way through a frame
        run(3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 333);
        run(3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 77);
        run(3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 50);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule